// File: doc/BRIEF.md
# Control-Flow and Stack Sequencer

This block carries out the control-transfer and stack instructions of an 8-bit processor core with a 16-bit address space. These are the absolute jump, the indirect jump, the subroutine call, the subroutine return, the return from interrupt, and the push and pull of the accumulator and the status byte. An upstream decoder hands it an operation code and a 16-bit operand, which is the target address or the pointer address. The block then steps through the instruction over a single byte-wide synchronous memory port, with at most one access per cycle. It owns the program counter and the 8-bit stack pointer. The stack is held in page 0x01.

The accumulator and status byte are owned elsewhere. The block reads them from `acc_in` and `stat_in`. In the last cycle of a pull it returns new values through one-cycle write strobes. `busy` is high for exactly the instruction's cycle count, and `done` marks the last cycle. While `done` is high, `cyc_count` gives the count.

The block keeps two conventions that existing code relies on. An indirect jump never carries its pointer into the next page. A call saves the return address minus one, and the matching return adds the one back.

Top module: `cf_stack_seq`

## Requirements
- R1: After reset, `pc` equals parameter RESET_PC (default 0x8000), `sp` equals RESET_SP (default 0xFD), `busy` and `done` are low, and no memory write is issued.
- R2: A `start` with `busy` low is accepted. From the next cycle, `busy` stays high for exactly N cycles, and `done` and `cyc_count`=N are shown in the last of them. The `op` codes and their N are: 0 absolute jump 3, 1 indirect jump 5, 2 call 6, 3 return 6, 4 interrupt return 6, 5 accumulator push 3, 6 status push 3, 7 accumulator pull 4, 8 status pull 4.
- R3: Absolute jump and call load `pc` with `operand`. `pc` changes only at the end of the last cycle of an instruction.
- R4: Indirect jump reads the target low byte at `operand` and the high byte at the same page with the low address byte plus one, modulo 256. A pointer ending in 0xFF therefore takes its high byte from offset 0x00 of its own page.
- R5: A push writes at 0x0100+`sp` and then decrements `sp`. A pull increments `sp` first and then reads 0x0100+`sp`. Both wrap modulo 256.
- R6: A call pushes `pc`-1, high byte first, then low byte.
- R7: A return pulls the low byte, then the high byte, and sets `pc` to that value plus one.
- R8: Interrupt return pulls the status byte, then the `pc` low byte, then the `pc` high byte, and sets `pc` with no offset.
- R9: Status push writes `stat_in` with bit 4 set. Status pull and interrupt return present the pulled byte with bit 5 forced to 1 on `stat_wdata`, with `stat_we` high.
- R10: Accumulator pull puts the pulled byte on `acc_wdata` with `acc_we` high. `stat_wdata` is `stat_in` with bit 7 set to the byte's bit 7 and bit 1 set when the byte is zero. `acc_we` and `stat_we` are high only in a `done` cycle.
- R11: A `start` while `busy` is high, or with an `op` code of 9 to 15, is ignored. The block stays idle or keeps to its current instruction, and `pc` and `sp` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| op | input | 4 | Operation code (see R2) |
| operand | input | 16 | Target address or pointer address |
| acc_in | input | 8 | Current accumulator value |
| stat_in | input | 8 | Current status byte |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| cyc_count | output | 3 | Cycle count of the instruction, valid with done |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | New accumulator value |
| stat_we | output | 1 | Status write strobe |
| stat_wdata | output | 8 | New status byte |

## Verification
Indirect jumps are tried with a pointer in mid-page and with a pointer ending in 0xFF. A different byte is placed at the next page, so a carry into the high address byte shows up as a wrong target. Call/return pairs and an interrupt return built from three accumulator pushes check byte order and the plus-one offset: swapped bytes or a missing increment give a distinct `pc`. Accumulator pulls of a negative, a zero and a positive byte are made against differing incoming status bytes, which separates N/Z updating from pass-through bits. A chain of pulls from 0xFD through 0x00 and a push back checks stack-pointer wrap in both directions.

// File: rtl/cfs_pkg.sv
// Package: shared constants, operation codes and micro-step types for the
// control-flow and stack sequencer. Assumes an 8-bit data path and a
// 16-bit address space with the stack held in one fixed page.
package cfs_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int OP_W    = 4;
    localparam int STEP_W  = 3;
    localparam int NBYTES  = 3;

    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;

    // status bit positions
    localparam int ST_NEG  = 7;
    localparam int ST_RSV  = 5;
    localparam int ST_BRK  = 4;
    localparam int ST_ZERO = 1;

    typedef enum logic [OP_W-1:0] {
        OP_JMP  = 4'd0,
        OP_JMPI = 4'd1,
        OP_CALL = 4'd2,
        OP_RET  = 4'd3,
        OP_RTI  = 4'd4,
        OP_PSHA = 4'd5,
        OP_PSHP = 4'd6,
        OP_PULA = 4'd7,
        OP_PULP = 4'd8
    } cf_op_e;

    typedef enum logic [2:0] {
        AK_IDLE,
        AK_PUSH,
        AK_PULL,
        AK_PTR_LO,
        AK_PTR_HI
    } acc_kind_e;

    typedef enum logic [1:0] {
        WS_RET_HI,
        WS_RET_LO,
        WS_ACC,
        WS_STAT
    } wsel_e;

    typedef struct packed {
        acc_kind_e kind;
        wsel_e     wsel;
    } uop_t;

    // cycle count for an operation code
    function automatic logic [STEP_W-1:0] op_cycles(input logic [OP_W-1:0] code);
        case (code)
            OP_JMP:  op_cycles = 3'd3;
            OP_JMPI: op_cycles = 3'd5;
            OP_CALL: op_cycles = 3'd6;
            OP_RET:  op_cycles = 3'd6;
            OP_RTI:  op_cycles = 3'd6;
            OP_PSHA: op_cycles = 3'd3;
            OP_PSHP: op_cycles = 3'd3;
            OP_PULA: op_cycles = 3'd4;
            OP_PULP: op_cycles = 3'd4;
            default: op_cycles = 3'd0;
        endcase
    endfunction

    // true for a defined operation code
    function automatic logic op_known(input logic [OP_W-1:0] code);
        op_known = (code <= OP_PULP);
    endfunction

endpackage

// File: rtl/cfs_uop_rom.sv
// Micro-step table: for the running operation and the current step
// (1-based), gives the memory access kind and the write-data source.
// Assumes steps beyond the last access return an idle step.
module cfs_uop_rom
    import cfs_pkg::*;
(
    input  logic              active,
    input  cf_op_e            op,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);

    // decode the access of this step
    always_comb begin
        uop = '{kind: AK_IDLE, wsel: WS_ACC};
        if (active) begin
            case (op)
                OP_JMPI: begin
                    if (step == 3'd1) uop.kind = AK_PTR_LO;
                    if (step == 3'd2) uop.kind = AK_PTR_HI;
                end
                OP_CALL: begin
                    if (step == 3'd1) uop = '{kind: AK_PUSH, wsel: WS_RET_HI};
                    if (step == 3'd2) uop = '{kind: AK_PUSH, wsel: WS_RET_LO};
                end
                OP_RET: begin
                    if (step <= 3'd2) uop.kind = AK_PULL;
                end
                OP_RTI: begin
                    if (step <= 3'd3) uop.kind = AK_PULL;
                end
                OP_PSHA: begin
                    if (step == 3'd1) uop = '{kind: AK_PUSH, wsel: WS_ACC};
                end
                OP_PSHP: begin
                    if (step == 3'd1) uop = '{kind: AK_PUSH, wsel: WS_STAT};
                end
                OP_PULA, OP_PULP: begin
                    if (step == 3'd1) uop.kind = AK_PULL;
                end
                default: uop.kind = AK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfs_stack_ptr.sv
// Stack pointer: post-decrement on push, pre-increment on pull, both
// modulo 2^DATA_W. Supplies the stack address for either access.
// Assumes push and pull are never requested in the same cycle.
module cfs_stack_ptr
    import cfs_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_SP = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pull,
    output logic [DATA_W-1:0] sp,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pull_addr
);

    logic [DATA_W-1:0] sp_inc;

    // next-above pointer for pulls
    assign sp_inc    = sp + 1'b1;
    assign push_addr = {STACK_PAGE, sp};
    assign pull_addr = {STACK_PAGE, sp_inc};

    // pointer update
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= RESET_SP;
        else if (push) sp <= sp - 1'b1;
        else if (pull) sp <= sp_inc;
    end

endmodule

// File: rtl/cfs_capture.sv
// Read capture: records each byte returned one cycle after a read was
// issued, in issue order, into NBYTES slots. Cleared when an instruction
// starts. Assumes no instruction issues more than NBYTES reads.
module cfs_capture
    import cfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bytes_q [NBYTES]
);

    localparam int IDX_W = $clog2(NBYTES + 1);

    logic             pend_q;
    logic [IDX_W-1:0] idx_q;

    // track outstanding read and slot index
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            pend_q <= rd_issue;
            if (pend_q) idx_q <= idx_q + 1'b1;
        end
    end

    // one storage slot per read in the instruction
    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[g] <= '0;
            else if (pend_q && (idx_q == IDX_W'(g)))
                bytes_q[g] <= rdata;
        end
    end

endmodule

// File: rtl/cf_stack_seq.sv
// Control-flow and stack sequencer top. Accepts one operation when idle,
// walks its micro-steps with at most one memory access per cycle, and in
// the final cycle updates pc and raises the accumulator/status strobes.
// Assumes acc_in/stat_in are held stable while busy.
module cf_stack_seq
    import cfs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h8000,
    parameter logic [DATA_W-1:0] RESET_SP = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] operand,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] stat_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] cyc_count,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] sp,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              stat_we,
    output logic [DATA_W-1:0] stat_wdata
);

    localparam int HI = ADDR_W - 1;
    localparam int LO = DATA_W;

    cf_op_e            op_q;
    logic [ADDR_W-1:0] opnd_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] n_cyc;
    logic              accept;
    logic              last;
    uop_t              uop;
    logic              do_push;
    logic              do_pull;
    logic              rd_issue;
    logic [ADDR_W-1:0] push_addr;
    logic [ADDR_W-1:0] pull_addr;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] ptr_hi_addr;
    logic [ADDR_W-1:0] pc_next;
    logic [DATA_W-1:0] got [NBYTES];
    logic [DATA_W-1:0] pulled_stat;

    assign accept = start && !busy && op_known(op);
    assign n_cyc  = op_cycles(op_q);
    assign last   = busy && (step_q == n_cyc);

    // operation register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            step_q <= '0;
            op_q   <= OP_JMP;
            opnd_q <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            step_q <= 3'd1;
            op_q   <= cf_op_e'(op);
            opnd_q <= operand;
        end else if (last) begin
            busy   <= 1'b0;
            step_q <= '0;
        end else if (busy) begin
            step_q <= step_q + 1'b1;
        end
    end

    cfs_uop_rom u_rom (
        .active (busy),
        .op     (op_q),
        .step   (step_q),
        .uop    (uop)
    );

    assign do_push  = (uop.kind == AK_PUSH);
    assign do_pull  = (uop.kind == AK_PULL);
    assign rd_issue = do_pull || (uop.kind == AK_PTR_LO) || (uop.kind == AK_PTR_HI);

    cfs_stack_ptr #(.RESET_SP(RESET_SP)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pull      (do_pull),
        .sp        (sp),
        .push_addr (push_addr),
        .pull_addr (pull_addr)
    );

    cfs_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .rd_issue (rd_issue),
        .rdata    (mem_rdata),
        .bytes_q  (got)
    );

    // return address saved by a call, and in-page pointer successor
    assign ret_addr    = pc - 1'b1;
    assign ptr_hi_addr = {opnd_q[HI:LO], opnd_q[LO-1:0] + 1'b1};

    // memory address and write data of this step
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        case (uop.kind)
            AK_PUSH:   mem_addr = push_addr;
            AK_PULL:   mem_addr = pull_addr;
            AK_PTR_LO: mem_addr = opnd_q;
            AK_PTR_HI: mem_addr = ptr_hi_addr;
            default:   mem_addr = '0;
        endcase
        if (do_push) begin
            case (uop.wsel)
                WS_RET_HI: mem_wdata = ret_addr[HI:LO];
                WS_RET_LO: mem_wdata = ret_addr[LO-1:0];
                WS_ACC:    mem_wdata = acc_in;
                default:   mem_wdata = stat_in | DATA_W'(1 << ST_BRK);
            endcase
        end
    end
    assign mem_we = do_push;

    // new program counter at the end of the operation
    always_comb begin
        case (op_q)
            OP_JMP, OP_CALL: pc_next = opnd_q;
            OP_JMPI:         pc_next = {got[1], got[0]};
            OP_RET:          pc_next = {got[1], got[0]} + 1'b1;
            OP_RTI:          pc_next = {got[2], got[1]};
            default:         pc_next = pc;
        endcase
    end

    // program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= RESET_PC;
        else if (last) pc <= pc_next;
    end

    // register write-back for pulls
    assign pulled_stat = got[0] | DATA_W'(1 << ST_RSV);
    always_comb begin
        acc_we     = 1'b0;
        acc_wdata  = got[0];
        stat_we    = 1'b0;
        stat_wdata = stat_in;
        if (last) begin
            case (op_q)
                OP_PULA: begin
                    acc_we              = 1'b1;
                    stat_we             = 1'b1;
                    stat_wdata[ST_NEG]  = got[0][ST_NEG];
                    stat_wdata[ST_ZERO] = (got[0] == '0);
                end
                OP_PULP, OP_RTI: begin
                    stat_we    = 1'b1;
                    stat_wdata = pulled_stat;
                end
                default: begin
                    acc_we  = 1'b0;
                    stat_we = 1'b0;
                end
            endcase
        end
    end

    assign done      = last;
    assign cyc_count = last ? n_cyc : '0;

endmodule

// File: rtl/cfs_seq_chk.sv
// Checker for the sequencer: timing of busy/done, stack pointer motion,
// stack-page writes, strobe placement and rejection of bad starts.
module cfs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  op,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  sp,
    input logic [15:0] pc,
    input logic        acc_we,
    input logic        stat_we
);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R3
    pc_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(pc));

    // R5
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - 8'd1);

    // R5
    push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[15:8] == 8'h01);

    // R10
    strobe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we || stat_we) |-> done);

    // R11
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && (op > 4'd8) |=> !busy);

endmodule

bind cf_stack_seq cfs_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .sp       (sp),
    .pc       (pc),
    .acc_we   (acc_we),
    .stat_we  (stat_we)
);

// File: tb/cf_stack_seq_tb.sv
`timescale 1ns/1ps
module cf_stack_seq_tb;

    typedef struct {
        logic [2:0]  cyc;
        logic        awe;
        logic [7:0]  a;
        logic        swe;
        logic [7:0]  s;
        logic [15:0] pc;
        logic [7:0]  sp;
        string       tag;
    } exp_t;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } wr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] operand = '0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  stat_in = '0;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, acc_we, stat_we;
    logic [2:0]  cyc_count;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  acc_wdata, stat_wdata;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] bmem [int];
    logic [7:0] mm [int];
    exp_t sbq[$];
    wr_t  wq[$];
    logic [15:0] m_pc = 16'h8000;
    logic [7:0]  m_sp = 8'hFD;

    always #4 clk = ~clk;

    cf_stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .acc_in(acc_in), .stat_in(stat_in), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .cyc_count(cyc_count), .pc(pc), .sp(sp), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata)
    );

    // bench memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    end

    function automatic logic [7:0] mrd(input logic [15:0] a);
        return mm.exists(int'(a)) ? mm[int'(a)] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        bmem[int'(a)] = d;
        mm[int'(a)]   = d;
    endtask

    // model a push
    task automatic m_push(input logic [7:0] d, input string tag);
        wr_t w;
        w.addr = {8'h01, m_sp}; w.data = d; w.tag = tag;
        wq.push_back(w);
        mm[int'(w.addr)] = d;
        m_sp = m_sp - 8'd1;
    endtask

    // model a pull
    function automatic logic [7:0] m_pull();
        m_sp = m_sp + 8'd1;
        return mrd({8'h01, m_sp});
    endfunction

    // driver: compute the expected result, then issue the operation
    task automatic issue(input logic [3:0] code, input logic [15:0] opnd,
                         input logic [7:0] a, input logic [7:0] p,
                         input string tag, input bit poke_busy = 0);
        exp_t e;
        logic [15:0] r;
        logic [7:0] v, lo, hi;
        e.awe = 0; e.a = 8'h00; e.swe = 0; e.s = p; e.tag = tag;
        case (code)
            4'd0: begin e.cyc = 3; m_pc = opnd; end
            4'd1: begin
                e.cyc = 5;
                lo = mrd(opnd);
                hi = mrd({opnd[15:8], opnd[7:0] + 8'd1});
                m_pc = {hi, lo};
            end
            4'd2: begin
                e.cyc = 6; r = m_pc - 16'd1;
                m_push(r[15:8], "R6"); m_push(r[7:0], "R6");
                m_pc = opnd;
            end
            4'd3: begin
                e.cyc = 6; lo = m_pull(); hi = m_pull();
                m_pc = {hi, lo} + 16'd1;
            end
            4'd4: begin
                e.cyc = 6; v = m_pull(); lo = m_pull(); hi = m_pull();
                m_pc = {hi, lo}; e.swe = 1; e.s = v | 8'h20;
            end
            4'd5: begin e.cyc = 3; m_push(a, "R5"); end
            4'd6: begin e.cyc = 3; m_push(p | 8'h10, "R9"); end
            4'd7: begin
                e.cyc = 4; v = m_pull(); e.awe = 1; e.a = v; e.swe = 1;
                e.s = {v[7], p[6:2], (v == 8'h00), p[0]};
            end
            default: begin
                e.cyc = 4; v = m_pull(); e.swe = 1; e.s = v | 8'h20;
            end
        endcase
        e.pc = m_pc; e.sp = m_sp;
        sbq.push_back(e);
        @(negedge clk);
        while (busy) @(negedge clk);
        op = code; operand = opnd; acc_in = a; stat_in = p; start = 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            op = 4'd5; operand = 16'hDEAD;
            @(negedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare design output against the scoreboard
    int    bcnt = 0;
    bit    post = 0;
    exp_t  cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (post) begin
                post = 0;
                check(pc == cur.pc, cur.tag, "pc", pc, cur.pc);
                check(sp == cur.sp, "R5", "sp", sp, cur.sp);
            end
            if (mem_we) begin
                if (wq.size() == 0) begin
                    check(0, "R11", "unexpected write", mem_addr, 0);
                end else begin
                    wr_t w;
                    w = wq.pop_front();
                    check(mem_addr == w.addr, w.tag, "write addr", mem_addr, w.addr);
                    check(mem_wdata == w.data, w.tag, "write data", mem_wdata, w.data);
                end
            end
            if ((acc_we || stat_we) && !done)
                check(0, "R10", "strobe outside done", {acc_we, stat_we}, 0);
            if (busy) bcnt++;
            if (done) begin
                if (sbq.size() == 0) begin
                    check(0, "R11", "unexpected done", 0, 0);
                end else begin
                    cur = sbq.pop_front();
                    check(cyc_count == cur.cyc, "R2", "cyc_count", cyc_count, cur.cyc);
                    check(bcnt == int'(cur.cyc), "R2", "busy cycles", bcnt, cur.cyc);
                    check(acc_we == cur.awe, "R10", "acc_we", acc_we, cur.awe);
                    if (cur.awe)
                        check(acc_wdata == cur.a, "R10", "acc_wdata", acc_wdata, cur.a);
                    check(stat_we == cur.swe, "R9", "stat_we", stat_we, cur.swe);
                    if (cur.swe)
                        check(stat_wdata == cur.s, cur.tag, "stat_wdata", stat_wdata, cur.s);
                    post = 1;
                end
                bcnt = 0;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R2", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pc == 16'h8000, "R1", "reset pc", pc, 16'h8000);
        check(sp == 8'hFD, "R1", "reset sp", sp, 8'hFD);
        check(!busy && !done && !mem_we, "R1", "reset idle", {busy, done, mem_we}, 0);

        poke(16'h3000, 8'h78); poke(16'h3001, 8'h56);
        poke(16'h30FF, 8'h11); poke(16'h3100, 8'hEE);
        poke(16'h0100, 8'h33);

        issue(4'd0, 16'h1234, 8'h00, 8'h00, "R3");          // R3 absolute jump
        issue(4'd1, 16'h3000, 8'h00, 8'h00, "R4");          // R4 mid-page pointer
        issue(4'd1, 16'h30FF, 8'h00, 8'h00, "R4");          // R4 page-wrap pointer
        issue(4'd2, 16'h4000, 8'h00, 8'h00, "R3");          // R3 R6 call
        issue(4'd3, 16'h0000, 8'h00, 8'h00, "R7");          // R7 return
        issue(4'd5, 16'h0000, 8'h5A, 8'h00, "R5");          // R5 push accumulator
        issue(4'd6, 16'h0000, 8'h00, 8'hC3, "R9");          // R9 push status
        issue(4'd8, 16'h0000, 8'h00, 8'h00, "R9");          // R9 pull status
        issue(4'd7, 16'h0000, 8'h00, 8'h00, "R10");         // R10 positive byte
        issue(4'd5, 16'h0000, 8'h80, 8'h00, "R5");
        issue(4'd7, 16'h0000, 8'h00, 8'h7F, "R10");         // R10 negative byte
        issue(4'd5, 16'h0000, 8'h00, 8'h00, "R5");
        issue(4'd7, 16'h0000, 8'h00, 8'h80, "R10");         // R10 zero byte
        issue(4'd5, 16'h0000, 8'h9A, 8'h00, "R5");
        issue(4'd5, 16'h0000, 8'hBC, 8'h00, "R5");
        issue(4'd5, 16'h0000, 8'h00, 8'h00, "R5");
        issue(4'd4, 16'h0000, 8'h00, 8'h00, "R8");          // R8 interrupt return
        issue(4'd2, 16'h2000, 8'h00, 8'h00, "R11", 1'b1);   // R11 start while busy
        issue(4'd3, 16'h0000, 8'h00, 8'h00, "R7");

        // R11 undefined code ignored
        @(negedge clk);
        op = 4'd9; operand = 16'hBEEF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(!busy, "R11", "undefined op busy", busy, 0);
        check(pc == m_pc, "R11", "undefined op pc", pc, m_pc);
        check(sp == m_sp, "R11", "undefined op sp", sp, m_sp);

        // R5 wrap: pull from 0xFD through 0x00, then push back down to 0xFF
        issue(4'd7, 16'h0000, 8'h00, 8'h00, "R5");
        issue(4'd7, 16'h0000, 8'h00, 8'h00, "R5");
        issue(4'd7, 16'h0000, 8'h00, 8'h00, "R5");
        issue(4'd5, 16'h0000, 8'h44, 8'h00, "R5");
        issue(4'd7, 16'h0000, 8'h00, 8'h00, "R5");

        repeat (2) @(negedge clk);
        check(sbq.size() == 0 && wq.size() == 0, "R2", "scoreboard drained",
              sbq.size() + wq.size(), 0);
        summary();
    end

endmodule